// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block places a small, fast line store between a processor request port and a slower byte-wide main-memory port. Each block of four bytes in the 24-bit address space can live in exactly one line of the store. The line is selected by the block number modulo the number of lines. Every line keeps a valid flag, a modified flag, a stored tag and the four data bytes.

A processor request that hits is answered on the next clock edge and causes no memory traffic. A write that hits changes only the stored byte and marks the line modified. On a miss the controller stops taking requests. If the line it must replace is valid and modified, it first copies that block back to memory. It then loads the whole new block from memory. Only after that does it complete the original read or write from the refreshed line.

The memory port moves one byte per handshake, and the memory may insert any number of wait cycles. The number of line-index bits is a parameter, so a simulation can use a tiny store.

Top module: `dmc_cache`

## Requirements
- R1: An address is split as follows: bits [1:0] give the byte within the block, the next INDEX_W bits give the line index, and the remaining upper bits give the tag. The line used is therefore the block number modulo 2^INDEX_W.
- R2: After a synchronous reset, cpu_ready is 1, and cpu_resp_valid and mem_req_valid are 0. Every line is invalid, so the first access to any address is a miss.
- R3: A hit needs the line to be valid and its stored tag to equal the address tag. A hit is answered with cpu_resp_valid in the cycle after acceptance, and it makes no memory request. For a read hit, cpu_resp_rdata carries the addressed byte.
- R4: A write hit updates the addressed byte in the line only (mem_req_write never rises for it) and marks the line modified.
- R5: A miss loads the block with four memory reads. They start at the block base {tag, index, 2'b00} and step through the bytes in ascending order. The response then comes from the refreshed line.
- R6: A miss whose line is valid and modified first writes the four old bytes to {stored tag, index, 2'b00} upward, and these bytes hold the latest values. A miss whose line is invalid or clean performs no memory write.
- R7: A write miss loads the block first, then merges the written byte into it and marks the line modified. Later reads and the eventual write-back carry the new byte.
- R8: From the cycle after a miss is accepted until the cycle in which its response is presented, cpu_ready is 0. cpu_ready is 1 again in the response cycle.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid, mem_req_write and mem_req_addr stay unchanged in the next cycle.
- R10: A completed load leaves the line valid and unmodified, holding the new tag. Replacing it later without any write causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present; taken when cpu_ready is 1 |
| cpu_req_write | input | 1 | 1 = write one byte, 0 = read one byte |
| cpu_req_addr | input | 24 | Byte address of the request |
| cpu_req_wdata | input | 8 | Byte to store on a write |
| cpu_ready | output | 1 | Controller idle and accepting a request |
| cpu_resp_valid | output | 1 | One-cycle completion flag of a request |
| cpu_resp_rdata | output | 8 | Read byte (written byte for writes) |
| mem_req_valid | output | 1 | Memory byte transfer requested |
| mem_req_write | output | 1 | 1 = write-back beat, 0 = load beat |
| mem_req_addr | output | 24 | Byte address of the beat |
| mem_req_wdata | output | 8 | Byte written on a write-back beat |
| mem_req_ready | input | 1 | Memory completes the beat at this edge |
| mem_rdata | input | 8 | Load byte, valid when mem_req_ready is 1 on a read beat |

## Verification
The bench builds the block with INDEX_W = 2, so there are only four lines and a 20-bit tag. With so few lines, a few tag values per index are enough to trigger evictions, thrashing between two blocks on one line, and write-backs of modified victims again and again. The same build also reaches the highest index and the highest byte offset. A tag of all ones exercises the full upper address field, and memory that stalls at random tests the hold rule of the handshake during both load and write-back.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W    = 24;
    localparam int BYTE_W    = 8;
    localparam int OFF_W     = 2;
    localparam int BLK_BYTES = 1 << OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } cpu_req_t;

    function automatic logic [OFF_W-1:0] byte_sel(input logic [ADDR_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [INDEX_W-1:0]                 rd_idx,
    output logic                               rd_valid,
    output logic                               rd_dirty,
    output logic [ADDR_W-INDEX_W-OFF_W-1:0]    rd_tag,
    output logic [BLK_BYTES-1:0][BYTE_W-1:0]   rd_data,
    input  logic [INDEX_W-1:0]                 wr_idx,
    input  logic [OFF_W-1:0]                   wr_off,
    input  logic                               fill_we,
    input  logic                               fill_last,
    input  logic [BYTE_W-1:0]                  fill_byte,
    input  logic [ADDR_W-INDEX_W-OFF_W-1:0]    fill_tag,
    input  logic                               cpu_we,
    input  logic [BYTE_W-1:0]                  cpu_byte
);
    localparam int LINES = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

    logic [LINES-1:0]                 vld_q;
    logic [LINES-1:0]                 dty_q;
    logic [TAG_W-1:0]                 tag_q [LINES];
    logic [BLK_BYTES-1:0][BYTE_W-1:0] dat_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            dty_q <= '0;
        end else if (fill_we && fill_last) begin
            vld_q[wr_idx] <= 1'b1;
            dty_q[wr_idx] <= 1'b0;
        end else if (cpu_we) begin
            dty_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            dat_q[wr_idx][wr_off] <= fill_byte;
        end else if (cpu_we) begin
            dat_q[wr_idx][wr_off] <= cpu_byte;
        end
        if (fill_we && fill_last) begin
            tag_q[wr_idx] <= fill_tag;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_dirty = dty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

    // R10
    fill_leaves_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_we && fill_last) |=>
            (vld_q[$past(wr_idx)] && !dty_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(fill_tag)));

    // R4
    store_marks_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_we |=> dty_q[$past(wr_idx)]);

    // R7
    no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(fill_we && cpu_we));

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cpu_req_valid,
    input  logic                               cpu_req_write,
    input  logic [ADDR_W-1:0]                  cpu_req_addr,
    input  logic [BYTE_W-1:0]                  cpu_req_wdata,
    output logic                               cpu_ready,
    output logic                               cpu_resp_valid,
    output logic [BYTE_W-1:0]                  cpu_resp_rdata,
    output logic                               mem_req_valid,
    output logic                               mem_req_write,
    output logic [ADDR_W-1:0]                  mem_req_addr,
    output logic [BYTE_W-1:0]                  mem_req_wdata,
    input  logic                               mem_req_ready,
    input  logic [BYTE_W-1:0]                  mem_rdata,
    output logic [INDEX_W-1:0]                 rd_idx,
    input  logic                               rd_valid,
    input  logic                               rd_dirty,
    input  logic [ADDR_W-INDEX_W-OFF_W-1:0]    rd_tag,
    input  logic [BLK_BYTES-1:0][BYTE_W-1:0]   rd_data,
    output logic [INDEX_W-1:0]                 wr_idx,
    output logic [OFF_W-1:0]                   wr_off,
    output logic                               fill_we,
    output logic                               fill_last,
    output logic [BYTE_W-1:0]                  fill_byte,
    output logic [ADDR_W-INDEX_W-OFF_W-1:0]    fill_tag,
    output logic                               cpu_we,
    output logic [BYTE_W-1:0]                  cpu_byte
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLK_BYTES - 1);

    ctl_state_e state_q;
    cpu_req_t   req_q;
    cpu_req_t   cur;
    logic [OFF_W-1:0] beat_q;
    logic [BYTE_W-1:0] rdata_q;
    logic       resp_q;

    logic [INDEX_W-1:0] cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [OFF_W-1:0]   cur_off;
    logic               accept;
    logic               hit;
    logic               serve;
    logic               beat_done;

    always_comb begin
        if (state_q == ST_IDLE) begin
            cur.write = cpu_req_write;
            cur.addr  = cpu_req_addr;
            cur.wdata = cpu_req_wdata;
        end else begin
            cur = req_q;
        end
    end

    assign cur_idx   = cur.addr[OFF_W +: INDEX_W];
    assign cur_tag   = cur.addr[ADDR_W-1 -: TAG_W];
    assign cur_off   = byte_sel(cur.addr);
    assign rd_idx    = cur_idx;
    assign accept    = (state_q == ST_IDLE) && cpu_req_valid;
    assign hit       = rd_valid && (rd_tag == cur_tag);
    assign serve     = (accept && hit) || (state_q == ST_DONE);
    assign beat_done = mem_req_valid && mem_req_ready;

    assign wr_idx    = cur_idx;
    assign wr_off    = (state_q == ST_FILL) ? beat_q : cur_off;
    assign fill_we   = (state_q == ST_FILL) && mem_req_ready;
    assign fill_last = (beat_q == LAST_BEAT);
    assign fill_byte = mem_rdata;
    assign fill_tag  = cur_tag;
    assign cpu_we    = serve && cur.write;
    assign cpu_byte  = cur.wdata;

    assign cpu_ready      = (state_q == ST_IDLE);
    assign cpu_resp_valid = resp_q;
    assign cpu_resp_rdata = rdata_q;
    assign mem_req_valid  = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign mem_req_write  = (state_q == ST_WBACK);
    assign mem_req_addr   = (state_q == ST_WBACK) ? {rd_tag, cur_idx, beat_q}
                                                  : {cur_tag, cur_idx, beat_q};
    assign mem_req_wdata  = rd_data[beat_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            beat_q  <= '0;
            resp_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            resp_q <= serve;
            if (serve) begin
                rdata_q <= cur.write ? cur.wdata : rd_data[cur_off];
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && !hit) begin
                        req_q   <= cur;
                        beat_q  <= '0;
                        state_q <= (rd_valid && rd_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (beat_done) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (beat_done) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    hit_answers_next_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> (cpu_resp_valid && !mem_req_valid));

    // R8
    busy_after_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> (!cpu_ready && !cpu_resp_valid));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R5
    ascending_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_done && mem_req_addr[OFF_W-1:0] != LAST_BEAT) |=>
            (mem_req_valid && mem_req_addr[OFF_W-1:0] == $past(mem_req_addr[OFF_W-1:0]) + 1'b1));

    // R6
    dirty_victim_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && rd_valid && rd_dirty) |=> (mem_req_valid && mem_req_write));

    // R6
    clean_victim_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && !(rd_valid && rd_dirty)) |=> (mem_req_valid && !mem_req_write));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int INDEX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [23:0]       cpu_req_addr,
    input  logic [7:0]        cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic [7:0]        cpu_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [23:0]       mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic [7:0]        mem_rdata
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;

    logic [INDEX_W-1:0]               rd_idx;
    logic                             rd_valid;
    logic                             rd_dirty;
    logic [TAG_W-1:0]                 rd_tag;
    logic [BLK_BYTES-1:0][BYTE_W-1:0] rd_data;
    logic [INDEX_W-1:0]               wr_idx;
    logic [OFF_W-1:0]                 wr_off;
    logic                             fill_we;
    logic                             fill_last;
    logic [BYTE_W-1:0]                fill_byte;
    logic [TAG_W-1:0]                 fill_tag;
    logic                             cpu_we;
    logic [BYTE_W-1:0]                cpu_byte;

    dmc_ctrl #(.INDEX_W(INDEX_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_ready      (cpu_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .mem_req_valid  (mem_req_valid),
        .mem_req_write  (mem_req_write),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_req_ready  (mem_req_ready),
        .mem_rdata      (mem_rdata),
        .rd_idx         (rd_idx),
        .rd_valid       (rd_valid),
        .rd_dirty       (rd_dirty),
        .rd_tag         (rd_tag),
        .rd_data        (rd_data),
        .wr_idx         (wr_idx),
        .wr_off         (wr_off),
        .fill_we        (fill_we),
        .fill_last      (fill_last),
        .fill_byte      (fill_byte),
        .fill_tag       (fill_tag),
        .cpu_we         (cpu_we),
        .cpu_byte       (cpu_byte)
    );

    dmc_line_store #(.INDEX_W(INDEX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_idx    (wr_idx),
        .wr_off    (wr_off),
        .fill_we   (fill_we),
        .fill_last (fill_last),
        .fill_byte (fill_byte),
        .fill_tag  (fill_tag),
        .cpu_we    (cpu_we),
        .cpu_byte  (cpu_byte)
    );

    // R2
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (cpu_ready && !cpu_resp_valid && !mem_req_valid));

endmodule

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX   = 2;
    localparam int LINES = 1 << IDX;
    localparam int TW    = 24 - IDX - 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [23:0] cpu_req_addr  = '0;
    logic [7:0]  cpu_req_wdata = '0;
    logic        cpu_ready;
    logic        cpu_resp_valid;
    logic [7:0]  cpu_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [23:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic [7:0]  mem_rdata     = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache #(.INDEX_W(IDX)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rdata(mem_rdata)
    );

    int unsigned checks = 0;
    int unsigned errs   = 0;

    logic [7:0] gold [logic [23:0]];
    logic [7:0] memm [logic [23:0]];

    bit          bm_v [LINES];
    bit          bm_d [LINES];
    logic [TW-1:0] bm_t [LINES];

    int unsigned wb_cnt, fill_cnt;
    logic [23:0] wb_base, fill_base;
    bit          pend_q = 1'b0;
    logic [23:0] pend_addr;
    bit          pend_wr;

    function automatic logic [7:0] init_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] gold_get(input logic [23:0] a);
        if (gold.exists(a)) return gold[a];
        return init_byte(a);
    endfunction

    function automatic logic [7:0] mem_get(input logic [23:0] a);
        if (memm.exists(a)) return memm[a];
        return init_byte(a);
    endfunction

    function automatic logic [23:0] mk(input logic [TW-1:0] t, input logic [IDX-1:0] i,
                                       input logic [1:0] o);
        return {t, i, o};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // memory responder: decides ready at the falling edge, records the beat it completes
    always @(negedge clk) begin
        if (!rst && mem_req_valid) begin
            bit rdy;
            if (pend_q) begin
                chk(mem_req_addr == pend_addr && mem_req_write == pend_wr, "R9",
                    "request held while stalled", mem_req_addr, pend_addr);
            end
            rdy = ($urandom % 3) == 0;
            mem_req_ready = rdy;
            mem_rdata     = mem_get(mem_req_addr);
            if (rdy) begin
                if (mem_req_write) begin
                    wb_cnt++;
                    if (wb_cnt == 1) wb_base = mem_req_addr;
                    chk(mem_req_addr == wb_base + 24'(wb_cnt - 1), "R6",
                        "write-back beat order", mem_req_addr, wb_base + 24'(wb_cnt - 1));
                    chk(mem_req_wdata == gold_get(mem_req_addr), "R6",
                        "write-back byte is latest", mem_req_wdata, gold_get(mem_req_addr));
                    memm[mem_req_addr] = mem_req_wdata;
                end else begin
                    fill_cnt++;
                    if (fill_cnt == 1) fill_base = mem_req_addr;
                    chk(mem_req_addr == fill_base + 24'(fill_cnt - 1), "R5",
                        "load beat order", mem_req_addr, fill_base + 24'(fill_cnt - 1));
                end
            end
            pend_q    = !rdy;
            pend_addr = mem_req_addr;
            pend_wr   = mem_req_write;
        end else begin
            mem_req_ready = 1'b0;
            pend_q        = 1'b0;
        end
    end

    // issues one request at a falling edge and checks its whole outcome against the model
    task automatic do_req(input bit wr, input logic [23:0] a, input logic [7:0] d);
        logic [IDX-1:0] idx;
        logic [TW-1:0]  tg;
        logic [TW-1:0]  old_tag;
        bit             exp_hit, exp_wb;
        logic [7:0]     exp_rd;
        int             cyc;
        idx     = a[IDX+1:2];
        tg      = a[23:IDX+2];
        old_tag = bm_t[idx];
        exp_hit = bm_v[idx] && (bm_t[idx] == tg);
        exp_wb  = !exp_hit && bm_v[idx] && bm_d[idx];
        exp_rd  = gold_get(a);
        wb_cnt   = 0;
        fill_cnt = 0;
        chk(cpu_ready == 1'b1, "R8", "ready before request", 32'(cpu_ready), 1);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cyc = 1;
        while (!cpu_resp_valid && cyc < 2000) begin
            if (cpu_ready) chk(1'b0, "R8", "ready during miss", 32'(cpu_ready), 0);
            @(negedge clk);
            cyc++;
        end
        chk(cpu_resp_valid == 1'b1, "R3", "response arrived", 32'(cpu_resp_valid), 1);
        chk(cpu_ready == 1'b1, "R8", "ready in response cycle", 32'(cpu_ready), 1);
        if (exp_hit) begin
            chk(cyc == 1, "R3", "hit latency", 32'(cyc), 1);
            chk(wb_cnt == 0 && fill_cnt == 0, wr ? "R4" : "R3", "hit memory beats",
                wb_cnt + fill_cnt, 0);
        end else begin
            chk(fill_cnt == 4, "R5", "load beat count", fill_cnt, 4);
            chk(fill_base == {tg, idx, 2'b00}, "R1", "load base address", fill_base,
                {tg, idx, 2'b00});
            chk(wb_cnt == (exp_wb ? 4 : 0), exp_wb ? "R6" : "R10", "write-back beat count",
                wb_cnt, exp_wb ? 4 : 0);
            if (exp_wb)
                chk(wb_base == {old_tag, idx, 2'b00}, "R6", "write-back base address",
                    wb_base, {old_tag, idx, 2'b00});
        end
        if (!wr)
            chk(cpu_resp_rdata == exp_rd, exp_hit ? "R3" : "R5", "read data",
                cpu_resp_rdata, exp_rd);
        if (wr) gold[a] = d;
        bm_v[idx] = 1'b1;
        bm_t[idx] = tg;
        bm_d[idx] = exp_hit ? (bm_d[idx] | wr) : wr;
    endtask

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < LINES; i++) begin
            bm_v[i] = 1'b0;
            bm_d[i] = 1'b0;
            bm_t[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(cpu_ready == 1'b1, "R2", "ready after reset", 32'(cpu_ready), 1);
        chk(cpu_resp_valid == 1'b0, "R2", "no response after reset", 32'(cpu_resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R2", "no memory request after reset", 32'(mem_req_valid), 0);

        // directed corner cases
        do_req(1'b0, mk(20'h1, 2'd0, 2'd0), 8'h00);   // R2 first access misses, clean
        do_req(1'b0, mk(20'h1, 2'd0, 2'd3), 8'h00);   // R3 hit
        do_req(1'b1, mk(20'h1, 2'd0, 2'd2), 8'hA5);   // R4 write hit
        do_req(1'b0, mk(20'h1, 2'd0, 2'd2), 8'h00);   // R4 read back
        do_req(1'b0, mk(20'h2, 2'd0, 2'd1), 8'h00);   // R6 dirty victim
        do_req(1'b0, mk(20'h1, 2'd0, 2'd2), 8'h00);   // R10 clean victim, memory holds A5
        do_req(1'b1, mk(20'h3, 2'd3, 2'd3), 8'h3C);   // R7 write miss, top index/offset
        do_req(1'b0, mk(20'h3, 2'd3, 2'd3), 8'h00);   // R7 merged byte visible
        do_req(1'b0, mk(20'h4, 2'd3, 2'd0), 8'h00);   // R7 eviction carries merged byte
        do_req(1'b0, mk(20'h3, 2'd3, 2'd3), 8'h00);   // R7 byte back from memory
        do_req(1'b0, mk(20'hFFFFF, 2'd3, 2'd1), 8'h00); // R1 full tag field
        do_req(1'b1, mk(20'hFFFFF, 2'd3, 2'd0), 8'h77);
        do_req(1'b1, mk(20'h00000, 2'd3, 2'd0), 8'h11);

        // constrained random traffic over a few tags per line
        for (int n = 0; n < 600; n++) begin
            logic [TW-1:0] t;
            bit wr;
            t  = ($urandom % 8 == 0) ? TW'($urandom) : TW'($urandom % 4);
            wr = ($urandom % 5) < 2;
            do_req(wr, mk(t, IDX'($urandom), 2'($urandom)), 8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule